// File: doc/BRIEF.md
# Register-Offset Load/Store Decode and Address Unit

This block takes a 32-bit load, store or prefetch instruction word of the register-offset class. It classifies the operation, reports the access width, the destination register width and sign handling, and flags undefined encodings. It also computes the effective address from a 64-bit base value and a 64-bit index register value. The caller supplies the base value already selected: a general register, or the stack pointer when the base field is 31. The block only requests a stack-pointer alignment check. It does not perform one.

The index operand is extended in one of four ways, picked by a 3-bit option field, and can then be scaled by the access size. The result is added to the base modulo 2^64. Every result is captured on a rising clock edge while `in_valid` is high and is presented one cycle later with `out_valid`. Words outside the class raise `not_class` and no other output. Undefined encodings raise `undef` and no other output.

Top module: `ldst_regoff_agu`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and is low otherwise. After reset (`rst_n` low), `out_valid` and every result output read zero.
- R2: An instruction word is in the class when bits 29:24 = 111000, bit 21 = 1 and bits 11:10 = 10. Any other word gives `not_class`=1, and every other result output is 0.
- R3: `undef`=1, with every other result output 0, when option bit 1 (word bit 14) is 0, or when size (bits 31:30) has bit 1 set and opc (bits 23:22) is 11.
- R4: When opc bit 1 is 0, the operation is a load if opc bit 0 is 1 and a store if it is 0. `op_class` encodes load as 01, store as 10 and prefetch as 11. For these operations `sign_ext`=0, and `reg_is64`=1 only when size is 11.
- R5: When opc bit 1 is 1 and size is not 11, the operation is a load with `sign_ext`=1. `reg_is64` is the inverse of opc bit 0.
- R6: Size 11 with opc 10 is a prefetch. It gives `pf_type` = Rt[4:3], `pf_level` = Rt[2:1] and `pf_stream` = Rt[0], with `reg_is64`=0 and `sign_ext`=0. The prefetch fields are 0 for every other operation.
- R7: For a decoded operation, `acc_bits` = 8 << size. `acc_bits` is 0 for undefined or out-of-class words.
- R8: Option 010 zero-extends index bits 31:0. Option 110 sign-extends index bits 31:0. Options 011 and 111 pass all 64 index bits unchanged.
- R9: When S (bit 12) is 1, the extended index is shifted left by size before the add. When S is 0, it is not shifted.
- R10: `eff_addr` = base + scaled index, truncated to 64 bits.
- R11: `sp_align_chk`=1 only when the base field Rn (bits 9:5) is 31 and the operation is a load or store. It is 0 for prefetch.
- R12: While `in_valid` is low, all result outputs keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the inputs |
| instr | input | 32 | Instruction word |
| base_val | input | 64 | Base operand (register or stack pointer) |
| index_val | input | 64 | Index register value |
| out_valid | output | 1 | Results valid, one cycle after `in_valid` |
| not_class | output | 1 | Word is outside the register-offset class |
| undef | output | 1 | Undefined encoding within the class |
| op_class | output | 2 | 00 none, 01 load, 10 store, 11 prefetch |
| acc_bits | output | 7 | Access width in bits |
| reg_is64 | output | 1 | Destination register is 64 bits wide |
| sign_ext | output | 1 | Loaded data is sign-extended |
| sp_align_chk | output | 1 | Stack-pointer alignment check requested |
| pf_type | output | 2 | Prefetch kind: 00 load, 01 instruction, 10 store |
| pf_level | output | 2 | Prefetch cache level: 00 first, 01 second, 10 third |
| pf_stream | output | 1 | Prefetch is streaming (1) or retained (0) |
| eff_addr | output | 64 | Effective address |

## Verification
The block holds no state other than its output register, so a decode or extension fault appears in the first `out_valid` cycle after the offending word. A wrong extend mode shows only when the index upper half, or bit 31 of the index, disagrees with the correct extension. For that reason the vectors set those bits deliberately, and also include an address carry out of bit 63. A broken capture enable shows at the ports as `eff_addr` changing during an idle cycle.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
  localparam int ADDR_W  = 64;
  localparam int INSTR_W = 32;
  localparam int ACCB_W  = 7;

  typedef enum logic [1:0] {
    MOP_NONE     = 2'd0,
    MOP_LOAD     = 2'd1,
    MOP_STORE    = 2'd2,
    MOP_PREFETCH = 2'd3
  } mem_op_e;

  typedef struct packed {
    mem_op_e    op;
    logic       undef;
    logic       not_class;
    logic       sgn;
    logic       r64;
    logic [1:0] size_log2;
    logic       sp_chk;
    logic [1:0] pf_type;
    logic [1:0] pf_level;
    logic       pf_stream;
    logic       scale_en;
    logic [2:0] ext_mode;
    logic       live;
  } dec_t;
endpackage

// File: rtl/ldst_regoff_decode.sv
module ldst_regoff_decode
  import ldst_agu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [1:0] f_size;
  logic [1:0] f_opc;
  logic [2:0] f_opt;
  logic [4:0] f_rn;
  logic [4:0] f_rt;
  logic       pattern_ok;
  logic       bad_enc;
  logic       live;
  mem_op_e    op_raw;

  assign f_size = instr[31:30];
  assign f_opc  = instr[23:22];
  assign f_opt  = instr[15:13];
  assign f_rn   = instr[9:5];
  assign f_rt   = instr[4:0];

  assign pattern_ok = (instr[29:24] == 6'b111000) && instr[21] && (instr[11:10] == 2'b10);
  assign bad_enc    = !f_opt[1] || (f_size[1] && (f_opc == 2'b11));
  assign live       = pattern_ok && !bad_enc;

  always_comb begin
    if (!f_opc[1])          op_raw = f_opc[0] ? MOP_LOAD : MOP_STORE;
    else if (f_size == 2'b11) op_raw = MOP_PREFETCH;
    else                    op_raw = MOP_LOAD;
  end

  always_comb begin
    dec           = '0;
    dec.not_class = !pattern_ok;
    dec.undef     = pattern_ok && bad_enc;
    if (live) begin
      dec.live      = 1'b1;
      dec.op        = op_raw;
      dec.size_log2 = f_size;
      dec.scale_en  = instr[12];
      dec.ext_mode  = f_opt;
      dec.sgn       = f_opc[1] && (f_size != 2'b11);
      dec.r64       = f_opc[1] ? ((f_size != 2'b11) && !f_opc[0]) : (f_size == 2'b11);
      dec.sp_chk    = (f_rn == 5'd31) && (op_raw != MOP_PREFETCH);
      if (op_raw == MOP_PREFETCH) begin
        dec.pf_type   = f_rt[4:3];
        dec.pf_level  = f_rt[2:1];
        dec.pf_stream = f_rt[0];
      end
    end
  end
endmodule

// File: rtl/ldst_index_ext.sv
module ldst_index_ext #(
  parameter int DATA_W = 64,
  parameter int LO_W   = 32
) (
  input  logic [DATA_W-1:0] idx_in,
  input  logic [2:0]        mode,
  input  logic              scale_en,
  input  logic [1:0]        size_log2,
  output logic [DATA_W-1:0] idx_out
);
  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] extended;
  logic              fill_bit;

  assign fill_bit = mode[2] && idx_in[LO_W-1];

  always_comb begin
    if (mode[0]) extended = idx_in;
    else         extended = {{HI_W{fill_bit}}, idx_in[LO_W-1:0]};
  end

  assign idx_out = scale_en ? (extended << size_log2) : extended;
endmodule

// File: rtl/ldst_regoff_agu.sv
module ldst_regoff_agu
  import ldst_agu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  index_val,
  output logic               out_valid,
  output logic               not_class,
  output logic               undef,
  output logic [1:0]         op_class,
  output logic [ACCB_W-1:0]  acc_bits,
  output logic               reg_is64,
  output logic               sign_ext,
  output logic               sp_align_chk,
  output logic [1:0]         pf_type,
  output logic [1:0]         pf_level,
  output logic               pf_stream,
  output logic [ADDR_W-1:0]  eff_addr
);
  dec_t              dec;
  logic [ADDR_W-1:0] idx_scaled;
  logic [ADDR_W-1:0] addr_nx;
  logic [ACCB_W-1:0] accb_nx;

  ldst_regoff_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  ldst_index_ext #(.DATA_W(ADDR_W), .LO_W(ADDR_W/2)) u_ext (
    .idx_in    (index_val),
    .mode      (dec.ext_mode),
    .scale_en  (dec.scale_en),
    .size_log2 (dec.size_log2),
    .idx_out   (idx_scaled)
  );

  always_comb begin
    addr_nx = '0;
    accb_nx = '0;
    if (dec.live) begin
      addr_nx = base_val + idx_scaled;
      accb_nx = ACCB_W'(8) << dec.size_log2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      not_class    <= 1'b0;
      undef        <= 1'b0;
      op_class     <= 2'b00;
      acc_bits     <= '0;
      reg_is64     <= 1'b0;
      sign_ext     <= 1'b0;
      sp_align_chk <= 1'b0;
      pf_type      <= 2'b00;
      pf_level     <= 2'b00;
      pf_stream    <= 1'b0;
      eff_addr     <= '0;
    end else if (in_valid) begin
      not_class    <= dec.not_class;
      undef        <= dec.undef;
      op_class     <= dec.op;
      acc_bits     <= accb_nx;
      reg_is64     <= dec.r64;
      sign_ext     <= dec.sgn;
      sp_align_chk <= dec.sp_chk;
      pf_type      <= dec.pf_type;
      pf_level     <= dec.pf_level;
      pf_stream    <= dec.pf_stream;
      eff_addr     <= addr_nx;
    end
  end
endmodule

// File: rtl/ldst_regoff_agu_chk.sv
module ldst_regoff_agu_chk
  import ldst_agu_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [INSTR_W-1:0] instr,
  input logic [ADDR_W-1:0]  base_val,
  input logic [ADDR_W-1:0]  index_val,
  input logic               out_valid,
  input logic               not_class,
  input logic               undef,
  input logic [1:0]         op_class,
  input logic [ACCB_W-1:0]  acc_bits,
  input logic               sp_align_chk,
  input logic [1:0]         pf_type,
  input logic [1:0]         pf_level,
  input logic               pf_stream,
  input logic [ADDR_W-1:0]  eff_addr
);
  logic in_class;
  assign in_class = (instr[29:24] == 6'b111000) && instr[21] && (instr[11:10] == 2'b10);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && not_class |-> (op_class == 2'b00) && !undef && (eff_addr == '0));
  a_r3_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && undef |-> (op_class == 2'b00) && (acc_bits == '0) && (eff_addr == '0));
  a_r3_option_bit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class && !instr[14] |=> undef);
  a_r6_pf_fields_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_class != 2'b11) |-> (pf_type == 2'b00) && (pf_level == 2'b00) && !pf_stream);
  a_r11_no_sp_on_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_class == 2'b11) |-> !sp_align_chk);
  a_r8_plain_index: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class && (instr[15:13] == 3'b011) && !instr[12] && !instr[23]
    |=> eff_addr == $past(base_val + index_val));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(eff_addr) && $stable(op_class));
endmodule

bind ldst_regoff_agu ldst_regoff_agu_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .instr        (instr),
  .base_val     (base_val),
  .index_val    (index_val),
  .out_valid    (out_valid),
  .not_class    (not_class),
  .undef        (undef),
  .op_class     (op_class),
  .acc_bits     (acc_bits),
  .sp_align_chk (sp_align_chk),
  .pf_type      (pf_type),
  .pf_level     (pf_level),
  .pf_stream    (pf_stream),
  .eff_addr     (eff_addr)
);

// File: tb/ldst_regoff_agu_tb_top.sv
module ldst_regoff_agu_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC       = 12;
  localparam int  WDOG_CYC   = 5000;

  typedef struct packed {
    logic [31:0] ins;
    logic [63:0] base;
    logic [63:0] idx;
    logic [63:0] addr;
    logic [1:0]  op;
    logic        und;
    logic        nc;
    logic        sgn;
    logic        r64;
    logic [6:0]  bits;
    logic        sp;
    logic [4:0]  pf;
  } vec_t;

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [1:0] opc,
                                     input logic [2:0] opt, input logic s,
                                     input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 6'b111000, opc, 1'b1, 5'd7, opt, s, 2'b10, rn, rt};
  endfunction

  localparam vec_t VEC [NVEC] = '{
    // R4 R8 R11: 64-bit load, plain index, base is SP
    '{mk(2'b11,2'b01,3'b011,1'b0,5'd31,5'd5), 64'h1000, 64'h20, 64'h1020, 2'b01,1'b0,1'b0,1'b0,1'b1,7'd64,1'b1,5'd0},
    // R4 R8 R9: 32-bit store, zero-extend, scaled by 4
    '{mk(2'b10,2'b00,3'b010,1'b1,5'd3,5'd5), 64'h100, 64'hFFFF_FFFF_0000_0004, 64'h110, 2'b10,1'b0,1'b0,1'b0,1'b0,7'd32,1'b0,5'd0},
    // R5 R8: byte signed load, sign-extend -1
    '{mk(2'b00,2'b10,3'b110,1'b1,5'd3,5'd5), 64'h2000, 64'h0000_0000_FFFF_FFFF, 64'h1FFF, 2'b01,1'b0,1'b0,1'b1,1'b1,7'd8,1'b0,5'd0},
    // R5 R9: half signed load into 32-bit, 64-bit signed index -4 << 1
    '{mk(2'b01,2'b11,3'b111,1'b1,5'd3,5'd5), 64'h3000, 64'hFFFF_FFFF_FFFF_FFFC, 64'h2FF8, 2'b01,1'b0,1'b0,1'b1,1'b0,7'd16,1'b0,5'd0},
    // R6 R11: prefetch, SP base, hint 10011
    '{mk(2'b11,2'b10,3'b011,1'b1,5'd31,5'b10011), 64'h40, 64'h2, 64'h50, 2'b11,1'b0,1'b0,1'b0,1'b0,7'd64,1'b0,5'b10011},
    // R10: address wraps past 2^64
    '{mk(2'b11,2'b01,3'b011,1'b0,5'd3,5'd5), 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 64'h10, 2'b01,1'b0,1'b0,1'b0,1'b1,7'd64,1'b0,5'd0},
    // R3: option bit 1 clear
    '{mk(2'b11,2'b01,3'b000,1'b0,5'd31,5'd5), 64'h1000, 64'h20, 64'h0, 2'b00,1'b1,1'b0,1'b0,1'b0,7'd0,1'b0,5'd0},
    // R3: size 11 opc 11
    '{mk(2'b11,2'b11,3'b011,1'b0,5'd3,5'd5), 64'h1000, 64'h20, 64'h0, 2'b00,1'b1,1'b0,1'b0,1'b0,7'd0,1'b0,5'd0},
    // R3: size 10 opc 11
    '{mk(2'b10,2'b11,3'b011,1'b0,5'd3,5'd5), 64'h1000, 64'h20, 64'h0, 2'b00,1'b1,1'b0,1'b0,1'b0,7'd0,1'b0,5'd0},
    // R5 R7 R9: word signed load to 64-bit, zero-extend, scaled by 4
    '{mk(2'b10,2'b10,3'b010,1'b1,5'd3,5'd5), 64'h0, 64'h0000_0000_8000_0001, 64'h2_0000_0004, 2'b01,1'b0,1'b0,1'b1,1'b1,7'd32,1'b0,5'd0},
    // R2: word outside class
    '{32'h0000_0000, 64'h1000, 64'h20, 64'h0, 2'b00,1'b0,1'b1,1'b0,1'b0,7'd0,1'b0,5'd0},
    // R4 R8: byte store, sign-extend 0x8000_0000
    '{mk(2'b00,2'b00,3'b110,1'b0,5'd3,5'd5), 64'h1_0000_0000, 64'h0000_0000_8000_0000, 64'h8000_0000, 2'b10,1'b0,1'b0,1'b0,1'b0,7'd8,1'b0,5'd0}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] base_val;
  logic [63:0] index_val;
  logic        out_valid, not_class, undef, reg_is64, sign_ext, sp_align_chk, pf_stream;
  logic [1:0]  op_class, pf_type, pf_level;
  logic [6:0]  acc_bits;
  logic [63:0] eff_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  ldst_regoff_agu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .base_val(base_val), .index_val(index_val), .out_valid(out_valid),
    .not_class(not_class), .undef(undef), .op_class(op_class), .acc_bits(acc_bits),
    .reg_is64(reg_is64), .sign_ext(sign_ext), .sp_align_chk(sp_align_chk),
    .pf_type(pf_type), .pf_level(pf_level), .pf_stream(pf_stream), .eff_addr(eff_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; base_val = '0; index_val = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1", "eff_addr after reset", eff_addr, 64'd0);
    chk("R1", "op_class after reset", 64'(op_class), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid idle", 64'(out_valid), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      in_valid = 1'b1; instr = VEC[i].ins; base_val = VEC[i].base; index_val = VEC[i].idx;
      @(negedge clk);
      chk("R1", "out_valid", 64'(out_valid), 64'd1);
      chk("R10", "eff_addr", eff_addr, VEC[i].addr);
      chk("R4", "op_class", 64'(op_class), 64'(VEC[i].op));
      chk("R3", "undef", 64'(undef), 64'(VEC[i].und));
      chk("R2", "not_class", 64'(not_class), 64'(VEC[i].nc));
      chk("R5", "sign_ext", 64'(sign_ext), 64'(VEC[i].sgn));
      chk("R5", "reg_is64", 64'(reg_is64), 64'(VEC[i].r64));
      chk("R7", "acc_bits", 64'(acc_bits), 64'(VEC[i].bits));
      chk("R11", "sp_align_chk", 64'(sp_align_chk), 64'(VEC[i].sp));
      chk("R6", "prefetch hint", 64'({pf_type, pf_level, pf_stream}), 64'(VEC[i].pf));
    end

    // R12: idle cycle with new operands must not change outputs
    in_valid = 1'b0; instr = VEC[0].ins; base_val = 64'hDEAD_0000; index_val = 64'h1;
    @(negedge clk);
    chk("R1", "out_valid after idle", 64'(out_valid), 64'd0);
    chk("R12", "eff_addr held", eff_addr, VEC[NVEC-1].addr);
    chk("R12", "op_class held", 64'(op_class), 64'(VEC[NVEC-1].op));
    @(negedge clk);
    chk("R12", "eff_addr held two cycles", eff_addr, VEC[NVEC-1].addr);

    // R9: S clear on a 64-bit access: no scaling
    in_valid = 1'b1; instr = mk(2'b11,2'b01,3'b011,1'b0,5'd3,5'd5);
    base_val = 64'h0; index_val = 64'h5;
    @(negedge clk);
    chk("R9", "unscaled index", eff_addr, 64'h5);
    // R9: S set on the same access: scaled by 8
    instr = mk(2'b11,2'b01,3'b011,1'b1,5'd3,5'd5);
    @(negedge clk);
    chk("R9", "scaled index", eff_addr, 64'h28);

    // R1: reset mid-stream clears outputs
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", "eff_addr on reset", eff_addr, 64'd0);
    chk("R1", "out_valid on reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule